// File: doc/BRIEF.md
# Serial Audio Word-Select Transmitter

This block is the timing and serialisation core of a two-channel serial audio transmitter. It counts bit clocks to build the word-select (WS) frame signal and shifts one left and one right sample out of each 32-bit word taken from an external transmit queue. Each clock cycle of `clk_i` is one bit-clock period. The frame length in bit clocks comes from a 6-bit setting. The sample length is 8 or 16 bits. A format select chooses between MSB-aligned output and the one-clock-delayed I2S alignment.

Each frame starts with WS low, which carries the left sample. WS then goes high for the right sample. With an odd setting, the high phase is one bit clock longer than the low phase. A separate trigger output pulses for one cycle on every WS rising edge, for use by an external converter. The trigger is gated by its own enable and by the counter enable, and does not depend on the transmit enable.

The queue is show-ahead: `fifo_data_i` is valid whenever `fifo_empty_i` is low, and a word is consumed on the rising edge where `fifo_pop_o` is high. All three serial outputs are registered. The value seen after rising edge k belongs to frame position k, so frame position 0 appears one cycle after the counter is first enabled.

Top module: `sai_ws_tx`

## Requirements
- R1: While `cnt_en_i` is high, a frame lasts P cycles, where P is the effective period. `ws_o` is low for the first floor(P/2) cycles of the frame and high for the rest. Frames repeat back to back.
- R2: For an odd P, the high phase of `ws_o` is exactly one cycle longer than the low phase.
- R3: If `period_i` is below the minimum, P is raised to that minimum. The minimum is 16 for 8-bit standard, 18 for 8-bit I2S, 32 for 16-bit standard and 34 for 16-bit I2S (`len16_i`=1 selects 16 bits, `i2s_i`=1 selects I2S).
- R4: The left sample is taken from word bits [31:16] and sent while `ws_o` is low. The right sample is taken from bits [15:0] and sent while `ws_o` is high. Both go out MSB first. In 8-bit mode the samples are bits [31:24] and [15:8].
- R5: With `i2s_i`=0, the MSB of a sample is driven in the first cycle of its WS phase. With `i2s_i`=1, it is driven in the second cycle.
- R6: Every phase cycle that does not carry a sample bit drives `sd_o` low.
- R7: `fifo_pop_o` is high only in the cycle before a frame's first output cycle, and only when `tx_en_i` is high and the queue is not empty. A frame that starts with an empty queue sends all zeros.
- R8: `trig_o` is high for exactly the cycle in which `ws_o` rises, if `trig_en_i` and `cnt_en_i` were both high, whatever the value of `tx_en_i`. Otherwise `trig_o` stays low.
- R9: While `tx_en_i` is low, `sd_o` is low and no word is consumed.
- R10: While `cnt_en_i` is low, `ws_o`, `sd_o` and `trig_o` are low one cycle later. The next enable restarts the frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bit-clock period per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Runs the frame counter |
| tx_en_i | input | 1 | Enables data fetch and serial data |
| trig_en_i | input | 1 | Enables the WS rising-edge trigger |
| period_i | input | 6 | Frame length setting in bit clocks |
| len16_i | input | 1 | 1: 16-bit samples, 0: 8-bit samples |
| i2s_i | input | 1 | 1: one-clock data delay after WS edge |
| fifo_data_i | input | 32 | Head word of the transmit queue |
| fifo_empty_i | input | 1 | Queue holds no word |
| fifo_pop_o | output | 1 | Consume the head word at this edge |
| ws_o | output | 1 | Word-select frame signal |
| sd_o | output | 1 | Serial data |
| trig_o | output | 1 | One-cycle pulse on WS rising edge |

## Verification
Assertions check several relations on every cycle: trigger pulses only on a WS rise and only with both enables, the effective period never drops below its format minimum, pops happen only at a frame start with transmit enabled and data present, and the outputs go quiet when the counter or the transmit enable is dropped. The exact bit stream depends on the chosen data length, format and period, so the bench's scenarios must show it. The scenarios cover channel order, the MSB position and the I2S delay, zero padding, odd-period asymmetry, clamping, and frames that start on an empty queue.

// File: rtl/sai_ws_pkg.sv
package sai_ws_pkg;
  localparam int CNT_W    = 6;
  localparam int SAMPLE_W = 16;
  localparam int SHORT_W  = 8;
  localparam int WORD_W   = 2 * SAMPLE_W;

  // Shortest legal frame: two samples, plus one delay slot per phase in I2S
  function automatic logic [CNT_W-1:0] min_period(input logic len16, input logic i2s);
    logic [CNT_W-1:0] m;
    m = len16 ? CNT_W'(2 * SAMPLE_W) : CNT_W'(2 * SHORT_W);
    if (i2s) m = m + CNT_W'(2);
    return m;
  endfunction
endpackage

// File: rtl/sai_frame_ctr.sv
module sai_frame_ctr
  import sai_ws_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          trig_en_i,
  input  logic [CW-1:0] period_i,
  input  logic          len16_i,
  input  logic          i2s_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] half_o,
  output logic          in_high_o,
  output logic          frame_start_o,
  output logic          ws_o,
  output logic          trig_o
);
  logic [CW-1:0] min_per, per_eff, half, cnt_q;
  logic          wrap, ws_q, trig_q;

  assign min_per = CW'(min_period(len16_i, i2s_i));
  assign per_eff = (period_i < min_per) ? min_per : period_i;
  assign half    = per_eff >> 1;        // low phase = floor(P/2)
  assign wrap    = cnt_q >= per_eff - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ws_q   <= 1'b0;
      trig_q <= 1'b0;
    end else if (!cnt_en_i) begin
      cnt_q  <= '0;
      ws_q   <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + CW'(1);
      ws_q   <= cnt_q >= half;
      trig_q <= trig_en_i && (cnt_q == half);
    end
  end

  assign cnt_o         = cnt_q;
  assign half_o        = half;
  assign in_high_o     = cnt_q >= half;
  assign frame_start_o = cnt_en_i && (cnt_q == '0);
  assign ws_o          = ws_q;
  assign trig_o        = trig_q;

  // R3: effective period never below the format minimum
  p_min_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_eff >= (CW'(16) + (len16_i ? CW'(16) : CW'(0)) + (i2s_i ? CW'(2) : CW'(0))));

  // R8: trigger only on the WS rising edge
  p_trig_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (ws_o && !$past(ws_o)));

  // R8: trigger needs both enables in the launching cycle
  p_trig_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(trig_en_i && cnt_en_i));

  // R10: counter disabled -> frame outputs quiet next cycle
  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> (!ws_o && !trig_o));
endmodule

// File: rtl/sai_bit_ser.sv
module sai_bit_ser
  import sai_ws_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int SW = SAMPLE_W,
  parameter int NW = SHORT_W,
  localparam int WW    = 2 * SW,
  localparam int IDX_W = $clog2(SW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          tx_en_i,
  input  logic          len16_i,
  input  logic          i2s_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] half_i,
  input  logic          in_high_i,
  input  logic          frame_start_i,
  input  logic [WW-1:0] fifo_data_i,
  input  logic          fifo_empty_i,
  output logic          fifo_pop_o,
  output logic          sd_o
);
  logic [WW-1:0]    word_q, cur_word;
  logic [SW-1:0]    samp;
  logic [CW-1:0]    pos, dly, len, bit_pos;
  logic [IDX_W-1:0] idx;
  logic             pop, slot_valid, bit_val, sd_q;

  assign pop      = frame_start_i && tx_en_i && !fifo_empty_i;
  // Word for position 0 comes straight from the queue head
  assign cur_word = frame_start_i ? (pop ? fifo_data_i : '0) : word_q;

  assign samp       = in_high_i ? cur_word[SW-1:0] : cur_word[WW-1:SW];
  assign pos        = in_high_i ? cnt_i - half_i : cnt_i;
  assign dly        = CW'(i2s_i);
  assign len        = len16_i ? CW'(SW) : CW'(NW);
  assign bit_pos    = pos - dly;
  assign slot_valid = (pos >= dly) && (bit_pos < len);
  assign idx        = IDX_W'(bit_pos);
  assign bit_val    = samp[IDX_W'(SW - 1) - idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (frame_start_i) word_q <= cur_word;
      sd_q <= cnt_en_i && tx_en_i && slot_valid && bit_val;
    end
  end

  assign fifo_pop_o = pop;
  assign sd_o       = sd_q;

  // R7: pop only at a frame start with data present
  p_pop_at_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (cnt_i == '0 && cnt_en_i && !fifo_empty_i));

  // R9: transmit disabled -> no consumption
  p_no_pop_tx_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !fifo_pop_o);

  // R9: transmit disabled -> data line low next cycle
  p_sd_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !sd_o);
endmodule

// File: rtl/sai_ws_tx.sv
module sai_ws_tx
  import sai_ws_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cnt_en_i,
  input  logic                tx_en_i,
  input  logic                trig_en_i,
  input  logic [CNT_W-1:0]    period_i,
  input  logic                len16_i,
  input  logic                i2s_i,
  input  logic [WORD_W-1:0]   fifo_data_i,
  input  logic                fifo_empty_i,
  output logic                fifo_pop_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                trig_o
);
  logic [CNT_W-1:0] cnt, half;
  logic             in_high, frame_start;

  sai_frame_ctr #(.CW(CNT_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_en_i     (cnt_en_i),
    .trig_en_i    (trig_en_i),
    .period_i     (period_i),
    .len16_i      (len16_i),
    .i2s_i        (i2s_i),
    .cnt_o        (cnt),
    .half_o       (half),
    .in_high_o    (in_high),
    .frame_start_o(frame_start),
    .ws_o         (ws_o),
    .trig_o       (trig_o)
  );

  sai_bit_ser #(.CW(CNT_W), .SW(SAMPLE_W), .NW(SHORT_W)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_en_i     (cnt_en_i),
    .tx_en_i      (tx_en_i),
    .len16_i      (len16_i),
    .i2s_i        (i2s_i),
    .cnt_i        (cnt),
    .half_i       (half),
    .in_high_i    (in_high),
    .frame_start_i(frame_start),
    .fifo_data_i  (fifo_data_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_pop_o   (fifo_pop_o),
    .sd_o         (sd_o)
  );
endmodule

// File: tb/sai_ws_tx_test.sv
module sai_ws_tx_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en = 1'b0, tx_en = 1'b0, trig_en = 1'b0;
  logic [5:0]  period = 6'd32;
  logic        len16 = 1'b1, i2s = 1'b0;
  logic        fifo_pop, ws, sd, trig;

  logic [31:0] mem [16];
  logic [3:0]  wr = '0, rd = '0;
  int          pop_cnt = 0;
  int          checks = 0, fails = 0;
  string       tag = "";

  typedef struct packed { logic ws; logic sd; logic trig; } item_t;
  item_t exp_q[$];
  int    pos_q[$];

  always #2 clk = ~clk;  // 250 MHz

  sai_ws_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .tx_en_i(tx_en),
    .trig_en_i(trig_en), .period_i(period), .len16_i(len16), .i2s_i(i2s),
    .fifo_data_i(mem[rd]), .fifo_empty_i(rd == wr), .fifo_pop_o(fifo_pop),
    .ws_o(ws), .sd_o(sd), .trig_o(trig)
  );

  always @(posedge clk) if (fifo_pop) begin
    rd      <= rd + 4'd1;
    pop_cnt <= pop_cnt + 1;
  end

  // Monitor: compares every output cycle against the scoreboard
  always @(negedge clk) if (exp_q.size() > 0) begin
    item_t e;
    int    k;
    e = exp_q.pop_front();
    k = pos_q.pop_front();
    checks++;
    if ({ws, sd, trig} !== {e.ws, e.sd, e.trig}) begin
      fails++;
      $display("FAIL %s pos %0d: ws/sd/trig=%b%b%b expected %b%b%b",
               tag, k, ws, sd, trig, e.ws, e.sd, e.trig);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Expected frame, built from R1-style rules stated in the brief
  task automatic push_frame(input logic [31:0] w, input int p, input int len,
                            input int dly, input bit te, input bit tx);
    int half;
    half = p / 2;
    for (int k = 0; k < p; k++) begin
      item_t e;
      bit    hi;
      int    pos, d;
      logic [15:0] s;
      hi  = (k >= half);
      pos = hi ? k - half : k;
      d   = pos - dly;
      s   = hi ? w[15:0] : w[31:16];
      e.ws   = hi;
      e.sd   = tx && (pos >= dly) && (d < len) ? s[15 - d] : 1'b0;
      e.trig = te && (k == half);
      exp_q.push_back(e);
      pos_q.push_back(k);
    end
  endtask

  task automatic run_case(input string req, input int nfr, input int pset, input bit l16,
                          input bit fmt, input bit tx, input bit te,
                          input logic [31:0] w0, input logic [31:0] w1, input int nwords);
    int minp, peff, p0;
    @(negedge clk);
    tag = req;
    if (nwords > 0) begin mem[wr] = w0; wr = wr + 4'd1; end
    if (nwords > 1) begin mem[wr] = w1; wr = wr + 4'd1; end
    minp = (l16 ? 32 : 16) + (fmt ? 2 : 0);
    peff = (pset < minp) ? minp : pset;
    period = 6'(pset); len16 = l16; i2s = fmt; tx_en = tx; trig_en = te;
    p0 = pop_cnt;
    cnt_en = 1'b1;
    @(posedge clk);
    for (int f = 0; f < nfr; f++)
      push_frame((tx && f < nwords) ? (f == 0 ? w0 : w1) : 32'h0, peff,
                 l16 ? 16 : 8, fmt ? 1 : 0, te, tx);
    wait (exp_q.size() == 0);
    cnt_en = 1'b0;
    #1;
    check({req, " R7 R9 pop count"}, 32'(pop_cnt - p0),
          32'(tx ? ((nwords < nfr) ? nwords : nfr) : 0));
    wr = rd;  // discard leftovers
    @(negedge clk);
    @(negedge clk);
    check("R10 idle outputs", {29'd0, ws, sd, trig}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {28'd0, ws, sd, trig, fifo_pop}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 after reset release", {28'd0, ws, sd, trig, fifo_pop}, 32'd0);

    // R1 R4 R5 R8: 16-bit standard, two words, trigger on
    run_case("R1 R4 R5 R8", 2, 32, 1, 0, 1, 1, 32'hA5C3_1E69, 32'h8001_7FFE, 2);
    // R5 R6: 8-bit I2S at minimum period, trigger off
    run_case("R5 R6 R8", 2, 18, 0, 1, 1, 0, 32'hC3FF_81FF, 32'h5A00_A500, 2);
    // R2: odd period, high phase longer
    run_case("R2", 1, 37, 1, 0, 1, 1, 32'hF00F_0FF0, 32'h0, 1);
    // R3: below minimum, 16-bit I2S -> 34
    run_case("R3 16b I2S", 1, 5, 1, 1, 1, 1, 32'h9669_3CC3, 32'h0, 1);
    // R3: below minimum, 8-bit standard -> 16
    run_case("R3 8b std", 1, 3, 0, 0, 1, 1, 32'hB7FF_6DFF, 32'h0, 1);
    // R7: second frame starts on an empty queue
    run_case("R7 empty", 2, 32, 1, 0, 1, 0, 32'hFFFF_FFFF, 32'h0, 1);
    // R8 R9: transmit off, trigger still active, word left unconsumed
    run_case("R8 R9 tx off", 2, 20, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0, 1);
    // R6: long period, 8-bit data padded with zeros
    run_case("R6 pad", 1, 40, 0, 0, 1, 1, 32'hFFFF_FFFF, 32'h0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule